// File: doc/BRIEF.md
# Boot-Block Address Map and Write Guard

This unit sits between a flash command decoder and the cell-array sequencer. It turns a 16-bit-word address into the index of one of nineteen erase blocks. Blocks are numbered 0 to 18 in ascending address order. The layout is non-uniform, with small boot and parameter blocks at one end of the space, and the `BOOT_TOP` parameter mirrors it between the low end and the high end.

The unit holds one lock bit per block. Lock bits are not cleared by the synchronous reset and start at all-ones (unlocked). For each requested program, erase or lock operation, it combines the addressed lock bit with a bypass pin and a three-level reset-pin indication, and either grants the operation or rejects it with an error. It also answers lock-status queries. It runs an erase-all sweep that walks every block in order and strobes an erase for each block the guard allows. Erasing under an override returns a block's lock bit to 1.

Top module: `boot_guard`

## Requirements
- R1: With `BOOT_TOP`=0 the word map is: 00000h–01FFFh block 0, 02000h–02FFFh block 1, 03000h–03FFFh block 2, 04000h–07FFFh block 3, and each following 32K-word region block 4 up to block 18 at 78000h–7FFFFh.
- R2: With `BOOT_TOP`=1 the map is: each 32K-word region from 00000h is block 0 to 14, 78000h–7BFFFh block 15, 7C000h–7CFFFh block 16, 7D000h–7DFFFh block 17, and 7E000h–7FFFFh block 18.
- R3: `rp_lvl` 2'b00 (low) or 2'b11 (treated as low) rejects every program, erase and lock operation with `rsp_err`=1, and the erase-all sweep strobes no block.
- R4: With `rp_lvl`=2'b01 and `lock_bypass`=0, an operation is granted exactly when the block's lock bit is 1; otherwise it is rejected.
- R5: With `lock_bypass`=1 (and `rp_lvl` 2'b01) or with `rp_lvl`=2'b10 (override), every block is writable regardless of its lock bit.
- R6: A granted erase performed under an override condition (R5) sets the block's lock bit to 1.
- R7: A granted lock operation clears the addressed block's lock bit to 0.
- R8: A query (`op_code` 3'd4) gives `rsp_vld`=1 with `rsp_grant`=`rsp_err`=0 and `rsp_stat` = {1'b0, lock bit, 6'b0}, where bit 6 = 1 means unlocked. `rsp_stat` is 0 for all other responses.
- R9: A rejected operation raises no `prg_go` or `ers_go` and changes no lock bit.
- R10: The erase-all op (3'd5) raises `sweep_busy` for 19 cycles. Block j, from 0 to 18, appears on `ers_blk` in the (j+2)-th cycle after the op, with `ers_go` high if the guard allows that block.
- R11: Any op presented while `sweep_busy` is high is ignored: no response is produced.
- R12: Synchronous reset clears all outputs and stops a sweep, but keeps every lock bit.
- R13: Op codes are 1 program, 2 erase, 3 lock, 4 query, 5 erase-all. Every response and strobe for a single op is registered and appears exactly one cycle after the op is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request this cycle |
| op_code | input | 3 | Operation code (R13) |
| addr | input | ADDR_W | Word address of the operation |
| rp_lvl | input | 2 | Reset-pin level: 00 low, 01 high, 10 override, 11 as low |
| lock_bypass | input | 1 | High makes all blocks writable when the reset pin is not low |
| rsp_vld | output | 1 | Response for a single op |
| rsp_grant | output | 1 | Operation granted |
| rsp_err | output | 1 | Operation rejected by protection |
| rsp_blk | output | BLK_W | Block index of the responded op |
| rsp_stat | output | 8 | Lock-status read value, bit 6 |
| prg_go | output | 1 | Program strobe to the array sequencer |
| ers_go | output | 1 | Erase strobe to the array sequencer |
| ers_blk | output | BLK_W | Block to erase |
| sweep_busy | output | 1 | Erase-all sweep in progress |

## Verification
Each single op is driven on a falling edge and its response, strobes and block index are sampled on the next falling edge. That is one register stage after the rising edge that captured the op. A query issued in the cycle after a lock or erase therefore observes the updated lock bit. The sweep is checked by sampling `sweep_busy` on the falling edge after the op, then `ers_go`/`ers_blk` on each of the 19 following falling edges, with `sweep_busy` expected low at the last of them. An op injected inside the sweep is checked for an absent response one cycle later.

// File: rtl/bmg_pkg.sv
package bmg_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_PROG  = 3'd1,
    OP_ERASE = 3'd2,
    OP_LOCK  = 3'd3,
    OP_QUERY = 3'd4,
    OP_SWEEP = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } op_e;

  localparam logic [1:0] RP_LOW  = 2'b00;
  localparam logic [1:0] RP_HIGH = 2'b01;
  localparam logic [1:0] RP_OVR  = 2'b10;
  localparam logic [1:0] RP_BAD  = 2'b11;

  // protection lifted for every block
  function automatic logic ovr_active(input logic [1:0] rp, input logic byp);
    return (rp == RP_OVR) || (byp && (rp == RP_HIGH));
  endfunction

  // final permission for one block
  function automatic logic may_write(input logic [1:0] rp, input logic byp,
                                     input logic lk);
    if ((rp == RP_LOW) || (rp == RP_BAD)) return 1'b0;
    return ovr_active(rp, byp) | lk;
  endfunction

endpackage

// File: rtl/bmg_addr_map.sv
module bmg_addr_map #(
  parameter int ADDR_W   = 19,
  parameter int BIG_LOG2 = 15,
  parameter bit BOOT_TOP = 1'b0,
  localparam int SEG_W   = ADDR_W - BIG_LOG2,
  localparam int NBIG    = (1 << SEG_W) - 1,
  localparam int NB      = NBIG + 4,
  localparam int BLK_W   = $clog2(NB)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BLK_W-1:0]  blk
);

  logic [SEG_W-1:0] seg;
  logic [2:0]       eighth;
  logic             unused_low_bits;

  assign seg             = addr[ADDR_W-1:BIG_LOG2];
  assign eighth          = addr[BIG_LOG2-1:BIG_LOG2-3];
  assign unused_low_bits = ^addr[BIG_LOG2-4:0];

  generate
    if (BOOT_TOP == 1'b0) begin : g_bottom
      always_comb begin
        if (seg == '0) begin
          if (eighth < 3'd2)       blk = BLK_W'(0);
          else if (eighth == 3'd2) blk = BLK_W'(1);
          else if (eighth == 3'd3) blk = BLK_W'(2);
          else                     blk = BLK_W'(3);
        end else begin
          blk = BLK_W'(seg) + BLK_W'(3);
        end
      end
    end else begin : g_top
      always_comb begin
        if (seg == '1) begin
          if (eighth < 3'd4)       blk = BLK_W'(NB - 4);
          else if (eighth == 3'd4) blk = BLK_W'(NB - 3);
          else if (eighth == 3'd5) blk = BLK_W'(NB - 2);
          else                     blk = BLK_W'(NB - 1);
        end else begin
          blk = BLK_W'(seg);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/bmg_lock_bank.sv
module bmg_lock_bank #(
  parameter int NB       = 19,
  parameter bit INIT_ONE = 1'b1,
  localparam int BLK_W   = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BLK_W-1:0] rd_a_idx,
  output logic             rd_a_bit,
  input  logic [BLK_W-1:0] rd_b_idx,
  output logic             rd_b_bit,
  input  logic             set_en,
  input  logic [BLK_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [BLK_W-1:0] clr_idx
);

  logic [NB-1:0] bits;

  // lock bits model non-volatile state: deliberately not reset
  genvar gi;
  generate
    for (gi = 0; gi < NB; gi++) begin : g_bit
      logic b_q = INIT_ONE;
      always_ff @(posedge clk) begin
        if (set_en && (set_idx == BLK_W'(gi)))      b_q <= 1'b1;
        else if (clr_en && (clr_idx == BLK_W'(gi))) b_q <= 1'b0;
      end
      assign bits[gi] = b_q;
    end
  endgenerate

  assign rd_a_bit = (32'(rd_a_idx) < NB) ? bits[rd_a_idx] : 1'b0;
  assign rd_b_bit = (32'(rd_b_idx) < NB) ? bits[rd_b_idx] : 1'b0;

  // R9: a cycle with no write request leaves all lock bits untouched
  p_bits_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!set_en && !clr_en) |=> $stable(bits));

  // R6/R7: set and clear never requested together
  p_set_clr_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(set_en && clr_en));

endmodule

// File: rtl/bmg_sweep.sv
module bmg_sweep #(
  parameter int NB     = 19,
  localparam int BLK_W = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             act,
  output logic [BLK_W-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0;
      ptr <= '0;
    end else if (start) begin
      act <= 1'b1;
      ptr <= '0;
    end else if (act) begin
      if (ptr == BLK_W'(NB - 1)) act <= 1'b0;
      else                       ptr <= ptr + 1'b1;
    end
  end

  // R10: the walk never leaves the block range
  p_ptr_range_r10: assert property (@(posedge clk) disable iff (rst)
    act |-> (32'(ptr) < NB));

endmodule

// File: rtl/boot_guard.sv
module boot_guard
  import bmg_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int BIG_LOG2 = 15,
  parameter bit BOOT_TOP = 1'b0,
  parameter bit INIT_ONE = 1'b1,
  localparam int NB      = (1 << (ADDR_W - BIG_LOG2)) + 3,
  localparam int BLK_W   = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        rp_lvl,
  input  logic              lock_bypass,
  output logic              rsp_vld,
  output logic              rsp_grant,
  output logic              rsp_err,
  output logic [BLK_W-1:0]  rsp_blk,
  output logic [7:0]        rsp_stat,
  output logic              prg_go,
  output logic              ers_go,
  output logic [BLK_W-1:0]  ers_blk,
  output logic              sweep_busy
);

  op_e              op;
  logic             accept, is_wr, ok_a, ok_b, ovr;
  logic [BLK_W-1:0] blk_a, sw_ptr;
  logic             bit_a, bit_b, sw_act;
  logic             set_en, clr_en;
  logic [BLK_W-1:0] set_idx;

  assign op     = op_e'(op_code);
  assign accept = op_valid && !sw_act;
  assign is_wr  = (op == OP_PROG) || (op == OP_ERASE) || (op == OP_LOCK);
  assign ovr    = ovr_active(rp_lvl, lock_bypass);
  assign ok_a   = may_write(rp_lvl, lock_bypass, bit_a);
  assign ok_b   = may_write(rp_lvl, lock_bypass, bit_b);

  bmg_addr_map #(.ADDR_W(ADDR_W), .BIG_LOG2(BIG_LOG2), .BOOT_TOP(BOOT_TOP)) map_i (
    .addr (addr),
    .blk  (blk_a)
  );

  bmg_sweep #(.NB(NB)) sweep_i (
    .clk   (clk),
    .rst   (rst),
    .start (accept && (op == OP_SWEEP)),
    .act   (sw_act),
    .ptr   (sw_ptr)
  );

  // erase under override restores the lock bit; lock op clears it
  assign set_en  = (accept && (op == OP_ERASE) && ok_a && ovr) ||
                   (sw_act && ok_b && ovr);
  assign set_idx = sw_act ? sw_ptr : blk_a;
  assign clr_en  = accept && (op == OP_LOCK) && ok_a;

  bmg_lock_bank #(.NB(NB), .INIT_ONE(INIT_ONE)) bank_i (
    .clk      (clk),
    .rst      (rst),
    .rd_a_idx (blk_a),
    .rd_a_bit (bit_a),
    .rd_b_idx (sw_ptr),
    .rd_b_bit (bit_b),
    .set_en   (set_en),
    .set_idx  (set_idx),
    .clr_en   (clr_en),
    .clr_idx  (blk_a)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld   <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_blk   <= '0;
      rsp_stat  <= 8'h00;
      prg_go    <= 1'b0;
      ers_go    <= 1'b0;
      ers_blk   <= '0;
    end else begin
      rsp_vld   <= accept && (is_wr || (op == OP_QUERY));
      rsp_grant <= accept && is_wr && ok_a;
      rsp_err   <= accept && is_wr && !ok_a;
      rsp_stat  <= (accept && (op == OP_QUERY)) ? {1'b0, bit_a, 6'b0} : 8'h00;
      prg_go    <= accept && (op == OP_PROG) && ok_a;
      ers_go    <= (accept && (op == OP_ERASE) && ok_a) || (sw_act && ok_b);
      if (accept) rsp_blk <= blk_a;
      if (sw_act)      ers_blk <= sw_ptr;
      else if (accept) ers_blk <= blk_a;
    end
  end

  assign sweep_busy = sw_act;

  // R3: reset pin low in the cycle of the op leaves all strobes quiet
  p_rp_low_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (($past(rp_lvl) == RP_LOW) || ($past(rp_lvl) == RP_BAD))
      |-> (!prg_go && !ers_go && !rsp_grant));

  // R9: a rejection never carries a strobe
  p_err_no_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (!prg_go && !ers_go));

  // R11: no response while a sweep was running
  p_sweep_mutes_rsp_r11: assert property (@(posedge clk) disable iff (rst)
    $past(sweep_busy) |-> !rsp_vld);

  // R10: the sweep ends on the last block
  p_sweep_last_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(sweep_busy) |-> (ers_blk == BLK_W'(NB - 1)));

  // R1: reported block index stays in range
  p_blk_range_r1: assert property (@(posedge clk) disable iff (rst)
    rsp_vld |-> (32'(rsp_blk) < NB));

endmodule

// File: tb/boot_guard_tb_top.sv
module boot_guard_tb_top;

  localparam int NB = 19;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic [18:0] addr = '0;
  logic [1:0]  rp_lvl = 2'b01;
  logic        lock_bypass = 1'b0;

  logic        rsp_vld, rsp_grant, rsp_err, prg_go, ers_go, sweep_busy;
  logic [4:0]  rsp_blk, ers_blk;
  logic [7:0]  rsp_stat;
  logic        t_vld, t_grant, t_err, t_prg, t_ers, t_busy;
  logic [4:0]  t_blk, t_eblk;
  logic [7:0]  t_stat;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  boot_guard #(.BOOT_TOP(1'b0)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .addr(addr),
    .rp_lvl(rp_lvl), .lock_bypass(lock_bypass), .rsp_vld(rsp_vld),
    .rsp_grant(rsp_grant), .rsp_err(rsp_err), .rsp_blk(rsp_blk),
    .rsp_stat(rsp_stat), .prg_go(prg_go), .ers_go(ers_go), .ers_blk(ers_blk),
    .sweep_busy(sweep_busy));

  boot_guard #(.BOOT_TOP(1'b1)) dut_top_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .addr(addr),
    .rp_lvl(rp_lvl), .lock_bypass(lock_bypass), .rsp_vld(t_vld),
    .rsp_grant(t_grant), .rsp_err(t_err), .rsp_blk(t_blk),
    .rsp_stat(t_stat), .prg_go(t_prg), .ers_go(t_ers), .ers_blk(t_eblk),
    .sweep_busy(t_busy));

  typedef struct packed {
    logic [18:0] a;
    logic [4:0]  bot;
    logic [4:0]  top;
  } mv_t;

  localparam mv_t MV [16] = '{
    '{19'h00000, 5'd0,  5'd0},  '{19'h01FFF, 5'd0,  5'd0},
    '{19'h02000, 5'd1,  5'd0},  '{19'h02FFF, 5'd1,  5'd0},
    '{19'h03000, 5'd2,  5'd0},  '{19'h04000, 5'd3,  5'd0},
    '{19'h07FFF, 5'd3,  5'd0},  '{19'h08000, 5'd4,  5'd1},
    '{19'h77FFF, 5'd17, 5'd14}, '{19'h78000, 5'd18, 5'd15},
    '{19'h7BFFF, 5'd18, 5'd15}, '{19'h7C000, 5'd18, 5'd16},
    '{19'h7D000, 5'd18, 5'd17}, '{19'h7DFFF, 5'd18, 5'd17},
    '{19'h7E000, 5'd18, 5'd18}, '{19'h7FFFF, 5'd18, 5'd18}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive on a falling edge, return on the next falling edge (results due)
  task automatic do_op(input logic [2:0] c, input logic [18:0] a,
                       input logic [1:0] rp, input logic byp);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; addr = a; rp_lvl = rp; lock_bypass = byp;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic query_bit(input string req, input logic [18:0] a, input logic exp);
    do_op(3'd4, a, 2'b01, 1'b0);
    chk(req, {24'b0, rsp_stat}, {24'b0, 1'b0, exp, 6'b0});
  endtask

  task automatic sweep(input string req, input logic [1:0] rp, input logic byp,
                       input logic [NB-1:0] exp_go);
    do_op(3'd5, '0, rp, byp);
    chk({req, " busy"}, 32'(sweep_busy), 32'd1);
    for (int j = 0; j < NB; j++) begin
      if (j == 3) begin op_valid = 1'b1; op_code = 3'd4; end
      @(negedge clk);
      op_valid = 1'b0;
      chk({req, " go"}, 32'(ers_go), 32'(exp_go[j]));
      chk({req, " blk"}, 32'(ers_blk), j);
      if (j == 3) chk("R11 op ignored during sweep", 32'(rsp_vld), 32'd0);
    end
    chk({req, " done"}, 32'(sweep_busy), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R12 reset rsp_vld", 32'(rsp_vld), 32'd0);
    chk("R12 reset busy", 32'(sweep_busy), 32'd0);
    chk("R12 reset ers_go", 32'(ers_go), 32'd0);
    rst = 1'b0;

    // table: map in both layouts; all blocks start unlocked
    for (int i = 0; i < 16; i++) begin
      do_op(3'd4, MV[i].a, 2'b01, 1'b0);
      chk("R13 query rsp_vld", 32'(rsp_vld), 32'd1);
      chk("R1 bottom map", 32'(rsp_blk), 32'(MV[i].bot));
      chk("R2 top map", 32'(t_blk), 32'(MV[i].top));
      chk("R8 query stat", 32'(rsp_stat), 32'h40);
      chk("R8 query no grant/err", {rsp_grant, rsp_err}, 2'b00);
    end

    // lock block 5 (10000h)
    do_op(3'd3, 19'h10000, 2'b01, 1'b0);
    chk("R7 lock granted", {rsp_grant, rsp_err}, 2'b10);
    chk("R8 stat zero on non-query", 32'(rsp_stat), 32'd0);
    query_bit("R7 lock bit cleared", 19'h10000, 1'b0);

    do_op(3'd1, 19'h10000, 2'b01, 1'b0);
    chk("R4 program locked rejected", {rsp_grant, rsp_err, prg_go}, 3'b010);
    do_op(3'd2, 19'h10000, 2'b01, 1'b0);
    chk("R9 erase locked no strobe", {rsp_err, ers_go}, 2'b10);
    query_bit("R9 lock bit unchanged", 19'h10000, 1'b0);

    do_op(3'd1, 19'h00000, 2'b01, 1'b0);
    chk("R4 program unlocked granted", {rsp_grant, rsp_err, prg_go}, 3'b101);
    @(negedge clk);
    chk("R13 strobe lasts one cycle", 32'(prg_go), 32'd0);

    do_op(3'd1, 19'h00000, 2'b00, 1'b1);
    chk("R3 rp low program rejected", {rsp_grant, rsp_err, prg_go}, 3'b010);
    do_op(3'd2, 19'h00000, 2'b11, 1'b0);
    chk("R3 rp 11 erase rejected", {rsp_grant, rsp_err, ers_go}, 3'b010);
    do_op(3'd3, 19'h00000, 2'b00, 1'b0);
    chk("R3 rp low lock rejected", {rsp_grant, rsp_err}, 2'b01);
    query_bit("R9 rejected lock keeps bit", 19'h00000, 1'b1);

    do_op(3'd2, 19'h10000, 2'b01, 1'b1);
    chk("R5 bypass erase granted", {rsp_grant, ers_go}, 2'b11);
    chk("R5 erase block", 32'(ers_blk), 32'd5);
    query_bit("R6 bypass erase unlocks", 19'h10000, 1'b1);

    do_op(3'd3, 19'h10000, 2'b01, 1'b0);
    do_op(3'd3, 19'h02000, 2'b01, 1'b0);
    do_op(3'd2, 19'h02000, 2'b10, 1'b0);
    chk("R5 override erase granted", {rsp_grant, ers_go}, 2'b11);
    query_bit("R6 override erase unlocks", 19'h02000, 1'b1);
    do_op(3'd3, 19'h7FFFF, 2'b01, 1'b0);
    do_op(3'd2, 19'h00000, 2'b01, 1'b0);
    chk("R4 erase unlocked granted", {rsp_grant, ers_go}, 2'b11);
    query_bit("R6 plain erase keeps bit", 19'h00000, 1'b1);

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    query_bit("R12 lock bit survives reset", 19'h10000, 1'b0);

    sweep("R10 sweep guarded", 2'b01, 1'b0, ~((19'd1 << 5) | (19'd1 << 18)));
    query_bit("R10 sweep keeps lock", 19'h10000, 1'b0);
    sweep("R10 sweep bypass", 2'b01, 1'b1, '1);
    query_bit("R6 sweep bypass unlocks 5", 19'h10000, 1'b1);
    query_bit("R6 sweep bypass unlocks 18", 19'h7FFFF, 1'b1);
    sweep("R3 sweep rp low", 2'b00, 1'b0, '0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule